// File: doc/BRIEF.md
# Compact 16-bit Instruction Decoder

This block turns one fixed-length 16-bit instruction word into the control bundle for a small load/store core with sixteen general registers. Every register field is 4 bits wide. The opcode is the top nibble, bits 15:12, and it selects among five classes: the dense load/store group, register-register add, add of a signed 8-bit constant, a short PC-relative branch with no delay slot, and a move of an unsigned 12-bit constant.

For each word the block produces two register indices, a full-width immediate, an ALU operation code, the memory request controls and the branch flag. Any other word raises an illegal flag, and an illegal word requests no register write, no memory access and no branch.

The decoded bundle sits in one output register, so it is ready at the start of the stage that follows decode. The fetch logic presents a new word on `insn_i` every clock.

Top module: `dec16_top`

## Requirements
- R1: While `rst_n` is low, and after reset until the first decoded word arrives, every output is zero, whatever word is on `insn_i`.
- R2: A word sampled at a rising clock edge appears decoded on the outputs right after that edge and not before it. The latency is exactly one cycle.
- R3: Opcode 0, with fields n=insn[11:8], m=insn[7:4] and Z=insn[3:0], is a memory access. It sets `mem_req_o`=1, `reg_n_o`=n and `reg_m_o`=m. When Z[3]=0 it is a store: `mem_wr_o`=1 and `rf_we_o`=0. When Z[3]=1 it is a load: `mem_wr_o`=0 and `rf_we_o`=1.
- R4: For opcode 0, `addr_r0_o` equals Z[2]. A value of 0 selects register-only addressing, and a value of 1 selects the register plus R0.
- R5: For opcode 0, `mem_size_o` equals Z[1:0]: 00 is a byte, 01 is 16 bits, 10 is 32 bits and 11 is 64 bits. `mem_sext_o` is 1 for loads and 0 for stores.
- R6: A word 0x10nm (bits 11:8 equal to zero) is a register add. It gives `alu_op_o`=1, `rf_we_o`=1, `reg_n_o`=insn[7:4] and `reg_m_o`=insn[3:0].
- R7: A word 0xCnii adds a constant. It gives `alu_op_o`=2, `rf_we_o`=1 and `reg_n_o`=insn[11:8]. `imm_o` is insn[7:0] sign-extended to DATA_W.
- R8: A word 0xAzzz is a branch. It gives `branch_o`=1. `imm_o` is insn[11:0] sign-extended and then shifted left by one, and it serves as the offset from the next instruction's address. There is no register write and no memory request.
- R9: A word 0xBzzz moves a constant. It gives `alu_op_o`=3, `rf_we_o`=1 and `reg_n_o`=0 (R0). `imm_o` is insn[11:0] zero-extended.
- R10: The illegal words are those with opcodes 2–9, D, E and F, plus opcode 1 with any nonzero bit in 11:8. Each sets `illegal_o`=1 and all other outputs to zero.
- R11: After any word, at most one of these is active: memory request, nonzero ALU operation, branch, illegal.
- R12: Fields that an instruction class does not use read as zero. The immediate is zero for memory access and register add. Both register indices are zero for a branch. `reg_m_o` is zero for constant add and constant move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_i | input | 16 | Instruction word to decode |
| reg_n_o | output | 4 | Destination, or store data register |
| reg_m_o | output | 4 | Source or base register |
| imm_o | output | DATA_W | Immediate or branch offset |
| alu_op_o | output | 2 | 0 none, 1 add reg, 2 add imm, 3 move imm |
| rf_we_o | output | 1 | Register write enable |
| mem_req_o | output | 1 | Memory access request |
| mem_wr_o | output | 1 | 1 store, 0 load |
| mem_size_o | output | 2 | Access size code |
| mem_sext_o | output | 1 | Sign-extend load data |
| addr_r0_o | output | 1 | Add R0 to the base address |
| branch_o | output | 1 | PC-relative branch |
| illegal_o | output | 1 | Unknown encoding |

## Verification
The assertions compare each output with the word sampled one edge earlier. They assume that `insn_i` is stable at every sampling edge and carries no X or Z bits. They also rely on the reset having been seen for at least one edge, and they stay quiet for the edge at which reset is released. The stimulus drives a fresh, fully defined word only on falling edges and sweeps all 65536 encodings in order, so the assumptions hold and every class and every field value is covered.

// File: rtl/dec16_pkg.sv
package dec16_pkg;

    parameter int unsigned DATA_W = 32;
    localparam int unsigned REG_W = 4;

    typedef enum logic [1:0] {
        ALU_NOP    = 2'd0,
        ALU_ADD_RR = 2'd1,
        ALU_ADD_RI = 2'd2,
        ALU_MOV_I  = 2'd3
    } alu_op_e;

    typedef enum logic [3:0] {
        OPC_LDST   = 4'h0,
        OPC_ADD_RR = 4'h1,
        OPC_BRANCH = 4'hA,
        OPC_MOVI   = 4'hB,
        OPC_ADD_RI = 4'hC
    } opc_e;

    typedef struct packed {
        logic [REG_W-1:0]  reg_n;
        logic [REG_W-1:0]  reg_m;
        logic [DATA_W-1:0] imm;
        alu_op_e           alu_op;
        logic              rf_we;
        logic              mem_req;
        logic              mem_wr;
        logic [1:0]        mem_size;
        logic              mem_sext;
        logic              addr_r0;
        logic              branch;
        logic              illegal;
    } dec_t;

    localparam dec_t DEC_IDLE = '0;

endpackage

// File: rtl/dec16_ldst.sv
module dec16_ldst
    import dec16_pkg::*;
(
    input  logic [15:0] insn,
    output dec_t        res
);
    logic is_load;

    always_comb begin
        is_load      = insn[3];
        res          = DEC_IDLE;
        res.reg_n    = insn[11:8];
        res.reg_m    = insn[7:4];
        res.mem_req  = 1'b1;
        res.mem_wr   = ~is_load;
        res.rf_we    = is_load;
        res.mem_sext = is_load;
        res.addr_r0  = insn[2];
        res.mem_size = insn[1:0];
    end
endmodule

// File: rtl/dec16_arith.sv
module dec16_arith
    import dec16_pkg::*;
(
    input  logic [15:0] insn,
    output dec_t        res,
    output logic        legal
);
    localparam int unsigned IMM8_PAD  = DATA_W - 8;
    localparam int unsigned IMM12_PAD = DATA_W - 12;

    always_comb begin
        res   = DEC_IDLE;
        legal = 1'b0;
        case (insn[15:12])
            OPC_ADD_RR: begin
                legal      = (insn[11:8] == 4'h0);
                res.reg_n  = insn[7:4];
                res.reg_m  = insn[3:0];
                res.alu_op = ALU_ADD_RR;
                res.rf_we  = 1'b1;
            end
            OPC_ADD_RI: begin
                legal      = 1'b1;
                res.reg_n  = insn[11:8];
                res.imm    = {{IMM8_PAD{insn[7]}}, insn[7:0]};
                res.alu_op = ALU_ADD_RI;
                res.rf_we  = 1'b1;
            end
            OPC_MOVI: begin
                legal      = 1'b1;
                res.reg_n  = '0;
                res.imm    = {{IMM12_PAD{1'b0}}, insn[11:0]};
                res.alu_op = ALU_MOV_I;
                res.rf_we  = 1'b1;
            end
            default: begin
                legal = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dec16_branch.sv
module dec16_branch
    import dec16_pkg::*;
(
    input  logic [15:0] insn,
    output dec_t        res
);
    localparam int unsigned DISP_PAD = DATA_W - 13;

    always_comb begin
        res        = DEC_IDLE;
        res.branch = 1'b1;
        res.imm    = {{DISP_PAD{insn[11]}}, insn[11:0], 1'b0};
    end
endmodule

// File: rtl/dec16_top.sv
module dec16_top
    import dec16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       insn_i,
    output logic [3:0]        reg_n_o,
    output logic [3:0]        reg_m_o,
    output logic [DATA_W-1:0] imm_o,
    output logic [1:0]        alu_op_o,
    output logic              rf_we_o,
    output logic              mem_req_o,
    output logic              mem_wr_o,
    output logic [1:0]        mem_size_o,
    output logic              mem_sext_o,
    output logic              addr_r0_o,
    output logic              branch_o,
    output logic              illegal_o
);
    dec_t ldst_res;
    dec_t arith_res;
    dec_t br_res;
    logic arith_ok;
    dec_t dec_d;
    dec_t dec_q;

    dec16_ldst   u_ldst   (.insn(insn_i), .res(ldst_res));
    dec16_arith  u_arith  (.insn(insn_i), .res(arith_res), .legal(arith_ok));
    dec16_branch u_branch (.insn(insn_i), .res(br_res));

    always_comb begin
        dec_d = DEC_IDLE;
        case (insn_i[15:12])
            OPC_LDST:   dec_d = ldst_res;
            OPC_BRANCH: dec_d = br_res;
            OPC_ADD_RR, OPC_ADD_RI, OPC_MOVI: begin
                if (arith_ok) dec_d = arith_res;
                else          dec_d.illegal = 1'b1;
            end
            default:    dec_d.illegal = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= DEC_IDLE;
        else        dec_q <= dec_d;
    end

    assign reg_n_o    = dec_q.reg_n;
    assign reg_m_o    = dec_q.reg_m;
    assign imm_o      = dec_q.imm;
    assign alu_op_o   = dec_q.alu_op;
    assign rf_we_o    = dec_q.rf_we;
    assign mem_req_o  = dec_q.mem_req;
    assign mem_wr_o   = dec_q.mem_wr;
    assign mem_size_o = dec_q.mem_size;
    assign mem_sext_o = dec_q.mem_sext;
    assign addr_r0_o  = dec_q.addr_r0;
    assign branch_o   = dec_q.branch;
    assign illegal_o  = dec_q.illegal;

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!rf_we_o && !mem_req_o && !branch_o && alu_op_o == 2'd0)); // R10
    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req_o, alu_op_o != 2'd0, branch_o, illegal_o})); // R11
    AST_LDST_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(insn_i[15:12]) == 4'h0)
        |-> (mem_req_o && mem_wr_o == !$past(insn_i[3]) && rf_we_o == $past(insn_i[3]))); // R3
    AST_LDST_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(insn_i[15:12]) == 4'h0)
        |-> (addr_r0_o == $past(insn_i[2]))); // R4
    AST_LDST_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(insn_i[15:12]) == 4'h0)
        |-> (mem_size_o == $past(insn_i[1:0]))); // R5
    AST_BRANCH_OFS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(insn_i[15:12]) == 4'hA)
        |-> (branch_o && !imm_o[0] && imm_o[DATA_W-1] == $past(insn_i[11]) && !rf_we_o)); // R8
    AST_MOVI_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(insn_i[15:12]) == 4'hB)
        |-> (rf_we_o && reg_n_o == 4'h0 && imm_o[DATA_W-1:12] == '0)); // R9
    AST_ADDI_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(insn_i[15:12]) == 4'hC)
        |-> (imm_o[DATA_W-1] == $past(insn_i[7]) && reg_n_o == $past(insn_i[11:8]))); // R7
endmodule

// File: tb/dec16_top_bench.sv
`timescale 1ns/1ps
module dec16_top_bench;
    localparam int DW = 32;
    localparam int VW = 4 + 4 + DW + 2 + 1 + 1 + 1 + 2 + 1 + 1 + 1 + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   insn = 16'h0000;
    logic [3:0]    reg_n, reg_m;
    logic [DW-1:0] imm;
    logic [1:0]    alu_op, mem_size;
    logic          rf_we, mem_req, mem_wr, mem_sext, addr_r0, branch, illegal;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    dec16_top u_dec16_top (
        .clk(clk), .rst_n(rst_n), .insn_i(insn),
        .reg_n_o(reg_n), .reg_m_o(reg_m), .imm_o(imm), .alu_op_o(alu_op),
        .rf_we_o(rf_we), .mem_req_o(mem_req), .mem_wr_o(mem_wr),
        .mem_size_o(mem_size), .mem_sext_o(mem_sext), .addr_r0_o(addr_r0),
        .branch_o(branch), .illegal_o(illegal)
    );

    function automatic logic [VW-1:0] actual();
        return {reg_n, reg_m, imm, alu_op, rf_we, mem_req, mem_wr,
                mem_size, mem_sext, addr_r0, branch, illegal};
    endfunction

    function automatic logic [VW-1:0] expect_of(input logic [15:0] w);
        logic [3:0] rn, rm; logic [DW-1:0] im; logic [1:0] op, sz;
        logic we, rq, wr, sx, r0, br, il;
        int sval;
        {rn, rm, im, op, sz, we, rq, wr, sx, r0, br, il} = '0;
        case (w[15:12])
            4'h0: begin
                rn = w[11:8]; rm = w[7:4]; rq = 1;
                wr = (w[3] == 0); we = w[3]; sx = w[3];
                r0 = w[2]; sz = w[1:0];
            end
            4'h1: if (w[11:8] == 0) begin
                rn = w[7:4]; rm = w[3:0]; op = 2'd1; we = 1;
            end else il = 1;
            4'hC: begin
                rn = w[11:8]; op = 2'd2; we = 1;
                sval = (w[7:0] >= 128) ? int'(w[7:0]) - 256 : int'(w[7:0]);
                im = DW'(sval);
            end
            4'hA: begin
                br = 1;
                sval = (w[11:0] >= 2048) ? int'(w[11:0]) - 4096 : int'(w[11:0]);
                im = DW'(sval * 2);
            end
            4'hB: begin
                op = 2'd3; we = 1; im = DW'(int'(w[11:0]));
            end
            default: il = 1;
        endcase
        return {rn, rm, im, op, we, rq, wr, sz, sx, r0, br, il};
    endfunction

    function automatic string req_of(input logic [15:0] w);
        case (w[15:12])
            4'h0: return "R3/R4/R5/R12";
            4'h1: return (w[11:8] == 0) ? "R6/R12" : "R10";
            4'hC: return "R7/R12";
            4'hA: return "R8/R12";
            4'hB: return "R9/R12";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [VW-1:0] exp);
        n_checks++;
        if (actual() !== exp) begin
            n_fails++;
            $display("FAIL %s insn=%h actual=%h expected=%h", req, insn, actual(), exp);
        end
    endtask

    task automatic check_one_class();
        n_checks++;
        if ((int'(mem_req) + int'(alu_op != 0) + int'(branch) + int'(illegal)) > 1) begin
            n_fails++;
            $display("FAIL R11 insn=%h actual=%b expected=at most one",
                     insn, {mem_req, alu_op != 0, branch, illegal});
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [15:0] prev;
        // R1: outputs stay zero while reset holds, whatever the input
        insn = 16'hC1FF;
        repeat (3) @(negedge clk);
        check("R1", '0);
        insn = 16'h0008;
        @(negedge clk);
        check("R1", '0);
        rst_n = 1'b1;
        insn  = 16'hB123;
        // R2: nothing changes before the sampling edge
        #1;
        check("R2", '0);
        @(negedge clk);
        check("R2", expect_of(16'hB123));
        // R2: a second word replaces the first after exactly one edge
        insn = 16'hAFFF;
        #1;
        check("R2", expect_of(16'hB123));
        @(negedge clk);
        check("R2", expect_of(16'hAFFF));
        // full sweep of every encoding
        prev = 16'h0000;
        for (int v = 0; v < 65536; v++) begin
            insn = 16'(v);
            @(negedge clk);
            prev = 16'(v);
            check(req_of(prev), expect_of(prev));
            check_one_class();
        end
        // R1: reset again clears a decoded illegal word
        insn = 16'h2000;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", '0);
        done = 1;
        finish_run();
    end
endmodule